// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. A host raises a request with a direction flag, an address and (for writes) a data byte. It holds the request until a one-clock `done` pulse comes back. The block then produces the chip-select, output-enable and write-enable waveforms the memory needs. Every setup, pulse, hold and release window is given in nanoseconds and converted at elaboration into whole clock counts against the clock period parameter.

The memory has two chip selects of opposite polarity. It is selected only when the low-true select is low and the high-true select is high. The block drives both together: both are active inside a cycle and both are inactive otherwise. A write is ended by raising write enable. Address and write data stay on the bus for the hold count after that edge. A read keeps output enable low for the access count. It captures the bus on the last clock of that window and can chain straight into another read. A read followed by a write goes through a release window and an idle cycle before the data bus is driven again.

A retention request parks the memory deselected with output enable high. Host requests wait until the park and the recovery window that follows it have both finished.

Top module: `sram_cycle_ctl`

## Requirements
- R1: A synchronous reset puts every strobe at its inactive level in the next cycle, even in the middle of a cycle: mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and done=0.
- R2: The memory is selected (mem_cs_n=0 with mem_cs=1) only inside a host cycle. Whenever the block is idle, parked or recovering, mem_cs_n=1 and mem_cs=0.
- R3: A write keeps both selects active and drives address and data from its setup phase onward. It then holds mem_we_n low for the write-pulse count. With the defaults, done is seen 7 clocks after the clock edge that accepts the request.
- R4: After mem_we_n rises, the address, mem_dq_o and mem_dq_oe=1 stay unchanged for the hold count. The byte on the bus at that edge is the one stored.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_we_n and mem_oe_n are never low together.
- R6: A read holds mem_oe_n low for the access count and captures mem_dq_i on its last clock into rd_data. done is a single-clock pulse, seen together with valid rd_data 5 clocks after acceptance with the defaults.
- R7: If a new read request (req=1, req_write=0) is present in the cycle where done is high, the next access starts without deasserting mem_oe_n. Its done follows 5 clocks later.
- R8: A write request present in the cycle where a read's done is high first passes the output-release count and one idle cycle. With the defaults its done comes 10 clocks after the read's done.
- R9: While ret_req is 1 and the block has reached idle, the memory stays deselected with mem_oe_n=1 and mem_we_n=1. Pending requests are not started, and no done is given.
- R10: After ret_req falls, no cycle starts before the recovery count has elapsed. With the defaults, the first select appears 6 clocks after the clock edge that samples ret_req=0.
- R11: Each window in clocks is ceil(ns / CLK_NS) with a minimum of 1. At the default 8 ns clock the write pulse is 4 clocks, the hold 1, the read access 4, the release 2 and the recovery 4.
- R12: All 13 address bits stay unchanged on mem_addr through every phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Host address |
| req_wdata | input | 8 | Host write byte |
| ret_req | input | 1 | Retention park request (level) |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | 13 | Memory address bus |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_i | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_cs_n | output | 1 | Low-true chip select |
| mem_cs | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write enable |

## Verification
The bench memory model returns a poison byte until output enable has been low on an unchanged address for the full access window. A controller that captures one clock early therefore returns the wrong byte. The model stores whatever is on the bus one clock after write enable rises, so a missing hold window stores garbage. It also measures the write pulse, so a miscounted rounding shows up as a wrong width. A read chained into a read, a read followed by a write, a retention park with a pending write, and a reset in the middle of a pulse are each timed at the ports. Skipping the turnaround, starting work during recovery, or leaving write enable low after reset would each break one of those counts.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_WSETUP  = 4'd1,
      ST_WPULSE  = 4'd2,
      ST_WHOLD   = 4'd3,
      ST_RACC    = 4'd4,
      ST_RHOLD   = 4'd5,
      ST_RREL    = 4'd6,
      ST_RETAIN  = 4'd7,
      ST_RECOVER = 4'd8
   } seq_state_e;

   // nanoseconds to whole clocks, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

   // a loaded phase counts down without skipping
   p_timer_step_r11: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctl_pkg::*;
#(
   parameter int SU_CYC     = 1,
   parameter int WP_CYC     = 4,
   parameter int WH_CYC     = 1,
   parameter int RD_CYC     = 4,
   parameter int REL_CYC    = 2,
   parameter int REC_CYC    = 4,
   parameter int READ_CHAIN = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic req_write,
   input  logic ret_req,
   output logic accept,
   output logic wr_phase,
   output logic capture,
   output logic wdone,
   output logic cs_n_o,
   output logic cs_o,
   output logic oe_n_o,
   output logic we_n_o
);

   localparam int MAXC = imax(imax(imax(SU_CYC, WP_CYC), imax(WH_CYC, RD_CYC)),
                              imax(REL_CYC, REC_CYC));
   localparam int CW   = $clog2(MAXC + 1);
   localparam int RW   = $clog2(MAXC + 2);

   seq_state_e    state_q, state_d;
   logic          t_load, t_last, chain_ok, sel;
   logic [CW-1:0] t_val;

   sram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   generate
      if (READ_CHAIN != 0) begin : g_chain
         assign chain_ok = req & ~req_write & ~ret_req;
      end else begin : g_nochain
         assign chain_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      accept  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (ret_req)
               state_d = ST_RETAIN;
            else if (req) begin
               accept  = 1'b1;
               state_d = req_write ? ST_WSETUP : ST_RACC;
            end
         end
         ST_WSETUP:  if (t_last) state_d = ST_WPULSE;
         ST_WPULSE:  if (t_last) state_d = ST_WHOLD;
         ST_WHOLD:   if (t_last) state_d = ST_IDLE;
         ST_RACC:    if (t_last) state_d = ST_RHOLD;
         ST_RHOLD: begin
            state_d = ST_RREL;
            if (chain_ok) begin
               accept  = 1'b1;
               state_d = ST_RACC;
            end
         end
         ST_RREL:    if (t_last) state_d = ST_IDLE;
         ST_RETAIN:  if (!ret_req) state_d = ST_RECOVER;
         ST_RECOVER: begin
            if (ret_req)
               state_d = ST_RETAIN;
            else if (t_last)
               state_d = ST_IDLE;
         end
         default:    state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_WSETUP:  t_val = CW'(SU_CYC - 1);
         ST_WPULSE:  t_val = CW'(WP_CYC - 1);
         ST_WHOLD:   t_val = CW'(WH_CYC - 1);
         ST_RACC:    t_val = CW'(RD_CYC - 1);
         ST_RREL:    t_val = CW'(REL_CYC - 1);
         ST_RECOVER: t_val = CW'(REC_CYC - 1);
         default:    t_val = '0;
      endcase
   end

   assign t_load = (state_d != state_q) || (state_q == ST_RHOLD);

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   always_comb begin
      sel      = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                 (state_q == ST_WHOLD)  || (state_q == ST_RACC)   ||
                 (state_q == ST_RHOLD);
      cs_n_o   = ~sel;
      cs_o     = sel;
      oe_n_o   = ~((state_q == ST_RACC) || (state_q == ST_RHOLD));
      we_n_o   = ~(state_q == ST_WPULSE);
      wr_phase = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                 (state_q == ST_WHOLD);
      capture  = (state_q == ST_RACC)  && t_last;
      wdone    = (state_q == ST_WHOLD) && t_last;
   end

   // length of the current low run of write enable
   logic [RW-1:0] we_lo_run;
   always_ff @(posedge clk) begin
      if (rst)
         we_lo_run <= '0;
      else if (!we_n_o)
         we_lo_run <= we_lo_run + 1'b1;
      else
         we_lo_run <= '0;
   end

   p_pulse_len_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n_o) |-> (we_lo_run == RW'(WP_CYC)));

   p_park_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_RETAIN && ret_req) |=> (state_q == ST_RETAIN));

   p_recover_no_start_r10: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_RECOVER) |=> !wr_phase && oe_n_o);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
   parameter int AW = 13,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          accept,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_wdata,
   input  logic          wr_phase,
   input  logic          capture,
   input  logic          wdone,
   input  logic [DW-1:0] dq_i,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe,
   output logic [DW-1:0] rdata_q,
   output logic          done_q
);

   logic [DW-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
         end
         if (capture)
            rdata_q <= dq_i;
         done_q <= capture | wdone;
      end
   end

   assign dq_o  = wdata_q;
   assign dq_oe = wr_phase;

   p_addr_stable_r12: assert property (@(posedge clk) disable iff (rst)
      (wr_phase && $past(wr_phase)) |-> $stable(addr_q));

   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW              = 13,
   parameter int DW              = 8,
   parameter int CLK_NS          = 8,
   parameter int T_ADDR_SU_NS    = 0,
   parameter int T_DATA_SU_NS    = 20,
   parameter int T_WPULSE_NS     = 25,
   parameter int T_ADDR_HOLD_NS  = 5,
   parameter int T_DATA_HOLD_NS  = 3,
   parameter int T_WCYCLE_NS     = 25,
   parameter int T_ADDR_ACC_NS   = 25,
   parameter int T_OE_ACC_NS     = 12,
   parameter int T_OE_REL_NS     = 15,
   parameter int T_RECOVER_NS    = 25,
   parameter int READ_CHAIN      = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          ret_req,
   output logic [DW-1:0] rd_data,
   output logic          done,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   input  logic [DW-1:0] mem_dq_i,
   output logic          mem_dq_oe,
   output logic          mem_cs_n,
   output logic          mem_cs,
   output logic          mem_oe_n,
   output logic          mem_we_n
);

   localparam int SU_CYC  = ns_to_cyc(T_ADDR_SU_NS, CLK_NS);
   localparam int WP_CYC  = imax(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                                 ns_to_cyc(T_DATA_SU_NS, CLK_NS));
   localparam int WH_CYC  = imax(ns_to_cyc(T_ADDR_HOLD_NS, CLK_NS),
                                 ns_to_cyc(T_DATA_HOLD_NS, CLK_NS));
   localparam int RD_CYC  = imax(ns_to_cyc(T_ADDR_ACC_NS, CLK_NS),
                                 ns_to_cyc(T_OE_ACC_NS, CLK_NS));
   localparam int REL_CYC = ns_to_cyc(T_OE_REL_NS, CLK_NS);
   localparam int REC_CYC = ns_to_cyc(T_RECOVER_NS, CLK_NS);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_cycle_ctl: widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_cycle_ctl: clock period must be at least 1 ns");
      end
      if ((SU_CYC + WP_CYC + WH_CYC) * CLK_NS < T_WCYCLE_NS) begin : g_bad_wc
         $error("sram_cycle_ctl: write phases shorter than write cycle");
      end
   endgenerate

   logic accept, wr_phase, capture, wdone;

   sram_seq_fsm #(
      .SU_CYC     (SU_CYC),
      .WP_CYC     (WP_CYC),
      .WH_CYC     (WH_CYC),
      .RD_CYC     (RD_CYC),
      .REL_CYC    (REL_CYC),
      .REC_CYC    (REC_CYC),
      .READ_CHAIN (READ_CHAIN)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .req_write (req_write),
      .ret_req   (ret_req),
      .accept    (accept),
      .wr_phase  (wr_phase),
      .capture   (capture),
      .wdone     (wdone),
      .cs_n_o    (mem_cs_n),
      .cs_o      (mem_cs),
      .oe_n_o    (mem_oe_n),
      .we_n_o    (mem_we_n)
   );

   sram_data_path #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .acc_addr  (req_addr),
      .acc_wdata (req_wdata),
      .wr_phase  (wr_phase),
      .capture   (capture),
      .wdone     (wdone),
      .dq_i      (mem_dq_i),
      .addr_q    (mem_addr),
      .dq_o      (mem_dq_o),
      .dq_oe     (mem_dq_oe),
      .rdata_q   (rd_data),
      .done_q    (done)
   );

   p_no_contention_r5: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> mem_oe_n);

   p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(!mem_we_n && !mem_oe_n));

   p_we_selected_r2: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (!mem_cs_n && mem_cs && mem_dq_oe));

   p_hold_after_we_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

endmodule

// File: tb/test_sram_cycle_ctl.sv
module test_sram_cycle_ctl;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0, req_write = 1'b0, ret_req = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  rd_data, mem_dq_o, mem_dq_i;
   logic        done, mem_dq_oe, mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
   logic [12:0] mem_addr;

   always #4 clk = ~clk;

   sram_cycle_ctl i_sram_cycle_ctl (
      .clk(clk), .rst(rst), .req(req), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ret_req(ret_req),
      .rd_data(rd_data), .done(done), .mem_addr(mem_addr),
      .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe),
      .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n)
   );

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // memory model: 256 bytes on the low address bits
   logic [7:0]  mdl [256];
   int          acc_cyc = 0;
   logic [12:0] acc_addr_l = '0;
   logic        we_prev = 1'b1;
   int          wlo = 0;
   logic [12:0] last_wr_addr = '0;
   int          pulse_len = 0;
   int          bad_strobe = 0;
   wire         sel = !mem_cs_n && mem_cs;

   always @(negedge clk) begin
      if (sel && !mem_oe_n && mem_we_n) begin
         acc_cyc    <= (mem_addr == acc_addr_l && acc_cyc > 0) ? acc_cyc + 1 : 1;
         acc_addr_l <= mem_addr;
      end else
         acc_cyc <= 0;
      if (!rst) begin
         if (!mem_we_n) wlo <= wlo + 1;
         if (!we_prev && mem_we_n && sel) begin
            mdl[mem_addr[7:0]] <= mem_dq_oe ? mem_dq_o : 8'hBD;
            last_wr_addr       <= mem_addr;
            pulse_len          <= wlo;
            wlo                <= 0;
         end else if (mem_we_n)
            wlo <= 0;
         if ((mem_dq_oe && !mem_oe_n) || (!mem_we_n && !mem_oe_n) ||
             (!mem_we_n && !sel) || (mem_cs_n == mem_cs))
            bad_strobe <= bad_strobe + 1;
      end
      we_prev <= mem_we_n;
   end

   assign mem_dq_i = (acc_cyc >= 4) ? mdl[mem_addr[7:0]] : 8'hEE;

   task automatic start(input bit w, input logic [12:0] a, input logic [7:0] d);
      req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!done && n < 100);
   endtask

   // {write, address, data or expected read byte}
   localparam logic [21:0] VEC [8] = '{
      {1'b1, 13'h0011, 8'hA5}, {1'b1, 13'h1F22, 8'h3C},
      {1'b1, 13'h0833, 8'hFF}, {1'b1, 13'h0044, 8'h00},
      {1'b0, 13'h0011, 8'hA5}, {1'b0, 13'h1F22, 8'h3C},
      {1'b0, 13'h0833, 8'hFF}, {1'b0, 13'h0044, 8'h00}
   };

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
   end

   initial begin
      int n, n2, flag;
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && !done,
          "R1 reset strobes", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe, done}, 6'b101100);
      rst = 1'b0;
      @(negedge clk);
      chk(mem_cs_n && !mem_cs, "R2 idle deselected", {mem_cs_n, mem_cs}, 2'b10);

      // vector walk: R3 R4 R6 R11 R12
      for (int v = 0; v < 8; v++) begin
         repeat (4) @(negedge clk);
         start(VEC[v][21], VEC[v][20:8], VEC[v][7:0]);
         wait_done(n);
         req = 1'b0;
         if (VEC[v][21]) begin
            chk(n == 7, "R3 write latency", n, 7);
            chk(last_wr_addr == VEC[v][20:8], "R12 full write address", last_wr_addr, VEC[v][20:8]);
            chk(pulse_len == 4, "R11 write pulse clocks", pulse_len, 4);
         end else begin
            chk(n == 5, "R6 read latency", n, 5);
            chk(rd_data == VEC[v][7:0], "R4 R6 read data", rd_data, VEC[v][7:0]);
         end
      end

      // R7: chained reads keep output enable low
      repeat (4) @(negedge clk);
      start(1'b0, 13'h0011, 8'h00);
      wait_done(n);
      start(1'b0, 13'h1F22, 8'h00);
      flag = 0; n2 = 0;
      do begin @(negedge clk); n2++; if (mem_oe_n) flag = 1; end while (!done && n2 < 100);
      req = 1'b0;
      chk(n2 == 5, "R7 chained read period", n2, 5);
      chk(flag == 0, "R7 oe held low", flag, 0);
      chk(rd_data == 8'h3C, "R7 chained data", rd_data, 8'h3C);

      // R8: read then write
      repeat (4) @(negedge clk);
      start(1'b0, 13'h0833, 8'h00);
      wait_done(n);
      chk(rd_data == 8'hFF, "R8 read before write", rd_data, 8'hFF);
      start(1'b1, 13'h0055, 8'h5A);
      wait_done(n);
      req = 1'b0;
      chk(n == 10, "R8 turnaround latency", n, 10);
      repeat (4) @(negedge clk);
      start(1'b0, 13'h0055, 8'h00);
      wait_done(n);
      req = 1'b0;
      chk(rd_data == 8'h5A, "R8 write after read stored", rd_data, 8'h5A);

      // R9 R10: retention park with a pending write
      repeat (4) @(negedge clk);
      ret_req = 1'b1;
      @(negedge clk);
      chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n, "R9 parked",
          {mem_cs_n, mem_cs, mem_oe_n, mem_we_n}, 4'b1011);
      start(1'b1, 13'h0066, 8'h66);
      flag = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (done || !mem_we_n || sel || !mem_oe_n) flag = 1;
      end
      chk(flag == 0, "R9 request held off", flag, 0);
      ret_req = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!sel && n < 100);
      chk(n == 6, "R10 recovery before select", n, 6);
      wait_done(n);
      req = 1'b0;
      repeat (4) @(negedge clk);
      start(1'b0, 13'h0066, 8'h00);
      wait_done(n);
      req = 1'b0;
      chk(rd_data == 8'h66, "R9 held write completes", rd_data, 8'h66);

      // R1: reset in the middle of a write pulse
      repeat (4) @(negedge clk);
      start(1'b1, 13'h0077, 8'h77);
      repeat (3) @(negedge clk);
      chk(!mem_we_n, "R3 pulse active", mem_we_n, 0);
      rst = 1'b1; req = 1'b0;
      @(negedge clk);
      chk(mem_we_n && mem_cs_n && !mem_cs && !mem_dq_oe && mem_oe_n, "R1 reset mid write",
          {mem_we_n, mem_cs_n, mem_cs, mem_dq_oe, mem_oe_n}, 5'b11001);
      @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      chk(bad_strobe == 0, "R5 R2 strobe conflicts", bad_strobe, 0);
      report();
   end

endmodule